// File: doc/BRIEF.md
# Power-Mode Clock Gating Controller

This block decides which peripheral units get a clock. It holds three gating banks, one for each power state: run, sleep and deep sleep. Software reaches them through a simple register bus. Each bank holds one enable bit per unit. A registered enable vector is produced from one of the banks. The choice depends on the current power mode and on an auto-gating flag. When the flag is clear, the run bank governs in every mode. When it is set, the bank that matches the mode governs.

The block also screens bus accesses that aim at the peripheral address space. That space is split into fixed-size windows, one per unit. If the addressed unit has its clock enable low, the access is flagged as a bus fault in the same cycle and is not passed on. Otherwise a grant strobe forwards it to the unit. The clock cells, the sleep-entry sequencing and the peripherals themselves sit outside this block.

Top module: `cgate_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every bank reads back 0x1. This means only unit 0 is enabled and units 1 to 3 are gated. The enable output is 4'b0001.
- R2: A write to offset 0x100 (run bank), 0x110 (sleep bank) or 0x120 (deep-sleep bank) stores bits 3:0. Bit n enables unit n. A read of that offset returns the stored bits, and bits 31:4 always read as zero.
- R3: A write to any other offset changes no bank, and a read of any other offset returns zero.
- R4: While auto_gate is 0, the enable output follows the run bank for every power-mode code.
- R5: While auto_gate is 1, the power-mode code selects the bank. Code 00 selects the run bank and code 01 the sleep bank. Code 10 selects the deep-sleep bank, and so does code 11.
- R6: The enable output is registered. A change of bank content, mode or auto_gate appears on it exactly one clock after the edge at which the change was sampled.
- R7: A peripheral access strobe whose window is unit n (address bits 13:12), with enable bit n low, raises per_fault in that same cycle and keeps per_grant low.
- R8: A peripheral access to a unit whose enable bit is high raises per_grant in that same cycle with per_fault low. Without a strobe, both outputs stay low.
- R9: reg_rdata is zero in any cycle that is not a register read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pmode | input | 2 | Power mode: 00 run, 01 sleep, 10/11 deep sleep |
| auto_gate | input | 1 | Lets the sleep and deep-sleep banks take effect |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid during the read strobe |
| per_req | input | 1 | Peripheral access strobe |
| per_addr | input | 16 | Peripheral access address |
| per_grant | output | 1 | Access forwarded to the unit |
| per_fault | output | 1 | Access refused: unit unclocked |
| unit_clk_en | output | 4 | Registered per-unit clock enable |

## Verification
A wrong bank bit shows up as a readback mismatch in the first read of that offset. Unless the bank is unselected, it also shows on unit_clk_en one clock after it is written. A fault in the mode selection or the registering stage shows as an enable vector that is one cycle early, late or from the wrong bank. An enable vector out of step with the fault screen shows as a wrong per_fault or per_grant in the very cycle of the access. This is why the reference model is compared on every clock, across mode sweeps and random traffic.

// File: rtl/cgate_pkg.sv
// Package: shared constants and the power-mode encoding of the clock gating
// controller. Assumes three banks ordered run, sleep, deep sleep.
package cgate_pkg;
    localparam int NBANKS     = 3;
    localparam int BANK_RUN   = 0;
    localparam int BANK_SLEEP = 1;
    localparam int BANK_DEEP  = 2;

    typedef enum logic [1:0] {
        PM_RUN      = 2'b00,
        PM_SLEEP    = 2'b01,
        PM_DEEP     = 2'b10,
        PM_DEEP_ALT = 2'b11
    } pmode_e;
endpackage

// File: rtl/cgate_regs.sv
// Module: cgate_regs
// Holds the three gating banks behind a simple register bus. Bank b sits
// at REG_BASE + b*REG_STRIDE. Only the low NUNITS bits are stored; the rest
// read as zero. Assumes a single-cycle strobe protocol with combinational
// read data and no wait states.
module cgate_regs
    import cgate_pkg::*;
#(
    parameter int          NUNITS     = 4,
    parameter int          ADDR_W     = 12,
    parameter int          DATA_W     = 32,
    parameter int          REG_BASE   = 'h100,
    parameter int          REG_STRIDE = 'h10,
    parameter logic [NUNITS-1:0] RST_VAL = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_sel,
    input  logic                          reg_wr,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata,
    output logic [NBANKS-1:0][NUNITS-1:0] bank_q
);
    localparam int PAD_W = DATA_W - NUNITS;

    logic [NBANKS-1:0] hit;

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_BASE + b * REG_STRIDE);

        // Decode whether this bank is addressed.
        assign hit[b] = reg_sel && (reg_addr == OFFS);

        // Store the writable bits of this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[b] <= RST_VAL;
            end else if (hit[b] && reg_wr) begin
                bank_q[b] <= reg_wdata[NUNITS-1:0];
            end
        end
    end

    // Return the addressed bank on a read, zero otherwise.
    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NBANKS; b++) begin
            if (hit[b] && !reg_wr) begin
                reg_rdata = {{PAD_W{1'b0}}, bank_q[b]};
            end
        end
    end

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:NUNITS] == '0);

    p_idle_rdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_sel && !reg_wr) |-> reg_rdata == '0);

    p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_sel && reg_wr) |=> $stable(bank_q));
endmodule

// File: rtl/cgate_sel.sv
// Module: cgate_sel
// Picks the governing bank from the power mode and the auto-gating flag and
// registers the result as the clock enable vector, so that a mode switch
// changes the enables only at a clock edge. Assumes pmode is synchronous.
module cgate_sel
    import cgate_pkg::*;
#(
    parameter int                NUNITS  = 4,
    parameter logic [NUNITS-1:0] RST_VAL = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    pmode,
    input  logic                          auto_gate,
    input  logic [NBANKS-1:0][NUNITS-1:0] bank_q,
    output logic [NUNITS-1:0]             en_q
);
    logic [NUNITS-1:0] pick;

    // Choose the bank that governs in the present mode.
    always_comb begin
        pick = bank_q[BANK_RUN];
        if (auto_gate) begin
            unique case (pmode_e'(pmode))
                PM_RUN:               pick = bank_q[BANK_RUN];
                PM_SLEEP:             pick = bank_q[BANK_SLEEP];
                PM_DEEP, PM_DEEP_ALT: pick = bank_q[BANK_DEEP];
                default:              pick = bank_q[BANK_RUN];
            endcase
        end
    end

    // Register the enable vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= RST_VAL;
        end else begin
            en_q <= pick;
        end
    end

    p_reset_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> en_q == RST_VAL);

    p_run_noauto_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(auto_gate)) |-> en_q == $past(bank_q[BANK_RUN]));

    p_deep_alt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(auto_gate) && $past(pmode[1]))
            |-> en_q == $past(bank_q[BANK_DEEP]));
endmodule

// File: rtl/cgate_fault.sv
// Module: cgate_fault
// Screens peripheral accesses. The unit is named by the address bits just
// above a 2**WIN_LG2 byte window. A strobe to an unclocked unit becomes a
// fault; a strobe to a clocked unit becomes a grant. Purely combinational.
module cgate_fault #(
    parameter int NUNITS  = 4,
    parameter int PADDR_W = 16,
    parameter int WIN_LG2 = 12
) (
    input  logic               per_req,
    input  logic [PADDR_W-1:0] per_addr,
    input  logic [NUNITS-1:0]  en,
    output logic               per_grant,
    output logic               per_fault
);
    localparam int UIDX_W = $clog2(NUNITS);

    logic [UIDX_W-1:0] uidx;
    logic              clk_ok;

    assign uidx = per_addr[WIN_LG2 +: UIDX_W];

    // Look up the enable of the addressed unit; absent units count as gated.
    always_comb begin
        clk_ok = 1'b0;
        for (int u = 0; u < NUNITS; u++) begin
            if (uidx == UIDX_W'(u)) begin
                clk_ok = en[u];
            end
        end
    end

    assign per_grant = per_req && clk_ok;
    assign per_fault = per_req && !clk_ok;
endmodule

// File: rtl/cgate_ctrl.sv
// Module: cgate_ctrl (top)
// Power-mode clock gating controller: register banks, bank selection with
// registered enables, and the bus-fault screen for peripheral accesses.
// Assumes one clock domain and a synchronous active-low reset.
module cgate_ctrl
    import cgate_pkg::*;
#(
    parameter int NUNITS  = 4,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int PADDR_W = 16,
    parameter int WIN_LG2 = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         pmode,
    input  logic               auto_gate,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               per_req,
    input  logic [PADDR_W-1:0] per_addr,
    output logic               per_grant,
    output logic               per_fault,
    output logic [NUNITS-1:0]  unit_clk_en
);
    localparam logic [NUNITS-1:0] RST_VAL = NUNITS'(1);
    localparam int                UIDX_W  = $clog2(NUNITS);

    logic [NBANKS-1:0][NUNITS-1:0] bank_q;

    cgate_regs #(
        .NUNITS(NUNITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .REG_BASE('h100), .REG_STRIDE('h10), .RST_VAL(RST_VAL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bank_q(bank_q)
    );

    cgate_sel #(.NUNITS(NUNITS), .RST_VAL(RST_VAL)) u_sel (
        .clk(clk), .rst_n(rst_n), .pmode(pmode), .auto_gate(auto_gate),
        .bank_q(bank_q), .en_q(unit_clk_en)
    );

    cgate_fault #(.NUNITS(NUNITS), .PADDR_W(PADDR_W), .WIN_LG2(WIN_LG2)) u_fault (
        .per_req(per_req), .per_addr(per_addr), .en(unit_clk_en),
        .per_grant(per_grant), .per_fault(per_fault)
    );

    p_gated_faults_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (per_req && !unit_clk_en[per_addr[WIN_LG2 +: UIDX_W]])
            |-> (per_fault && !per_grant));

    p_clocked_grants_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (per_req && unit_clk_en[per_addr[WIN_LG2 +: UIDX_W]])
            |-> (per_grant && !per_fault));

    p_quiet_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !per_req |-> !(per_grant || per_fault));
endmodule

// File: tb/sim_cgate_ctrl.sv
// Bench for cgate_ctrl: a behavioural reference model, stepped on every
// rising edge and compared with the design at every falling edge.
module sim_cgate_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pmode = 2'b00;
    logic        auto_gate = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        per_req = 1'b0;
    logic [15:0] per_addr = '0;
    logic        per_grant;
    logic        per_fault;
    logic [3:0]  unit_clk_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cgate_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pmode(pmode), .auto_gate(auto_gate),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
        .per_addr(per_addr), .per_grant(per_grant), .per_fault(per_fault),
        .unit_clk_en(unit_clk_en)
    );

    // Reference model state
    int m_bank [3];
    int m_en;

    function automatic int bank_of(input logic [11:0] a);
        if (a == 12'h100) return 0;
        if (a == 12'h110) return 1;
        if (a == 12'h120) return 2;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) m_bank[i] = 1;
            m_en = 1;
        end else begin
            if (!auto_gate || pmode == 2'b00) m_en = m_bank[0];
            else if (pmode == 2'b01)          m_en = m_bank[1];
            else                              m_en = m_bank[2];
            if (reg_sel && reg_wr && bank_of(reg_addr) >= 0)
                m_bank[bank_of(reg_addr)] = int'(reg_wdata) & 15;
        end
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        int     exp_rd;
        int     unit;
        string  rreq;
        exp_rd = 0;
        rreq = "R9";
        if (reg_sel && !reg_wr) begin
            if (bank_of(reg_addr) >= 0) begin
                exp_rd = m_bank[bank_of(reg_addr)];
                rreq = "R2";
            end else begin
                rreq = "R3";
            end
        end
        check(rreq, "reg_rdata", longint'(reg_rdata), longint'(exp_rd));
        check(auto_gate ? "R5/R6" : "R4/R6", "unit_clk_en", longint'(unit_clk_en), longint'(m_en));
        unit = int'(per_addr[13:12]);
        check("R7", "per_fault", longint'(per_fault), longint'(per_req && !m_en[unit]));
        check("R8", "per_grant", longint'(per_grant), longint'(per_req && m_en[unit]));
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        tick();
        reg_sel = 1'b0;
    endtask

    task automatic sweep_units();
        for (int u = 0; u < 4; u++) begin
            per_req = 1'b1;
            per_addr = 16'((u << 12) | 16'h0a4);
            tick();
        end
        per_req = 1'b0;
        tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1: reset values of banks and enables
        check("R1", "unit_clk_en after reset", longint'(unit_clk_en), 64'h1);
        for (int b = 0; b < 3; b++) begin
            reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = 12'(12'h100 + b * 16);
            @(negedge clk);
            check("R1", "bank after reset", longint'(reg_rdata), 64'h1);
            compare_all();
        end
        reg_sel = 1'b0;
        sweep_units();
        // R2: writes and readback, reserved bits drop
        wr(12'h100, 32'hFFFF_FFFA);
        wr(12'h110, 32'h0000_0006);
        wr(12'h120, 32'h8000_0009);
        rd(12'h100); rd(12'h110); rd(12'h120);
        // R3: unmapped offsets
        wr(12'h104, 32'hFFFF_FFFF);
        wr(12'h130, 32'hFFFF_FFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h104); rd(12'h130);
        rd(12'h100); rd(12'h110); rd(12'h120);
        // R4: auto gating off, every mode
        auto_gate = 1'b0;
        for (int m = 0; m < 4; m++) begin
            pmode = 2'(m);
            tick(); tick();
            sweep_units();
        end
        // R5: auto gating on, every mode incl. code 11
        auto_gate = 1'b1;
        for (int m = 0; m < 4; m++) begin
            pmode = 2'(m);
            tick(); tick();
            sweep_units();
        end
        // R6: write to the selected bank appears one clock later
        pmode = 2'b01;
        tick();
        wr(12'h110, 32'h0000_000F);
        tick();
        wr(12'h110, 32'h0000_0000);
        sweep_units();
        // Random traffic
        for (int i = 0; i < 400; i++) begin
            pmode = 2'($urandom_range(0, 3));
            auto_gate = 1'($urandom_range(0, 1));
            reg_sel = 1'($urandom_range(0, 1));
            reg_wr = 1'($urandom_range(0, 1));
            case ($urandom_range(0, 3))
                0: reg_addr = 12'h100;
                1: reg_addr = 12'h110;
                2: reg_addr = 12'h120;
                default: reg_addr = 12'($urandom_range(0, 4095));
            endcase
            reg_wdata = $urandom;
            per_req = 1'($urandom_range(0, 1));
            per_addr = 16'($urandom_range(0, 65535));
            tick();
        end
        reg_sel = 1'b0; per_req = 1'b0;
        // R1: reset again mid-run
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        check("R1", "unit_clk_en after second reset", longint'(unit_clk_en), 64'h1);
        rd(12'h120);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule